// File: doc/BRIEF.md
# Windowed Address Partition Translator

This block maps a fixed virtual address used by host software onto a physical device address. It uses a small set of programmable windows. Seven 32-bit configuration slots hold the base and length values for four partitions: a primary memory window, a register window and two auxiliary memory windows. Only the last of these windows has a base and no length.

Only the primary memory window and the register window take part in translation. In physical space, the primary memory area starts at zero and the register area sits directly after it. A register-window hit is therefore rebased to the primary memory length, not to its own base. Every other address is rebased against the primary memory base.

The two auxiliary windows are stored only so they can be read back. A request enters on a valid/ready port. The translated address comes out one cycle later on a registered valid/ready port, with a flag for a register-window hit and a flag for an address outside both translated windows.

Top module: `addr_window_xlate`

## Requirements
- R1: While and after reset, `rsp_valid` is 0 and every configuration slot reads back as 0.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` in slot `cfg_idx`, and `cfg_rd_data` returns slot `cfg_rd_idx` without delay. The slots are 0 memory base, 1 memory length, 2 register base, 3 register length, 4 aux-A base, 5 aux-A length and 6 aux-B base. Index 7 is not a slot: a write to it changes nothing, and reading it gives 0.
- R3: An address hits the register window when reg_base <= addr < reg_base + reg_len. The upper bound is computed in 33 bits, so it does not wrap.
- R4: On a register-window hit, `rsp_addr` = addr - reg_base + mem_len (modulo 2^32) and `rsp_hit_reg` = 1.
- R5: Without a register-window hit, `rsp_addr` = addr - mem_base (modulo 2^32) and `rsp_hit_reg` = 0.
- R6: `rsp_oor` = 1 exactly when there is no register-window hit and either addr < mem_base or addr >= mem_base + mem_len (33-bit sum). The R5 result is still returned in that case.
- R7: Slots 4, 5 and 6 have no effect on any translation result.
- R8: A request accepted at a clock edge appears on the response port at that same edge, with `rsp_valid` = 1. The response is consumed at the first edge where `rsp_ready` = 1.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, the response fields hold steady and `req_ready` is 0.
- R10: A request is translated using the configuration present before its accepting edge. A configuration write at that same edge, or at any later edge, does not change its response.
- R11: With `rsp_ready` held at 1, one request is accepted on every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Slot written |
| cfg_wdata | input | 32 | Value written |
| cfg_rd_idx | input | 3 | Slot read back |
| cfg_rd_data | output | 32 | Read-back value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_addr | input | 32 | Virtual address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 32 | Physical address |
| rsp_hit_reg | output | 1 | Register window matched |
| rsp_oor | output | 1 | Address outside both translated windows |

## Verification
The hardest case to reach is a configuration change that races a translation. It needs a write landing on the accepting edge, and another landing while a response is stalled. The bench first holds `rsp_ready` low so a response parks on the output. It then rewrites the memory base under it. Next it drives a request and a second rewrite in the same cycle, and checks that each response reflects the base in force before its own accepting edge. A vector walk covers the first and last address of each window and the address just past each one.

// File: rtl/apw_pkg.sv
package apw_pkg;

    localparam int AW      = 32;
    localparam int NUM_CFG = 7;
    localparam int IDX_W   = $clog2(NUM_CFG + 1);

    typedef logic [AW-1:0] addr_t;

    typedef enum logic [IDX_W-1:0] {
        SLOT_MEM_BASE  = 3'd0,
        SLOT_MEM_LEN   = 3'd1,
        SLOT_REG_BASE  = 3'd2,
        SLOT_REG_LEN   = 3'd3,
        SLOT_AUXA_BASE = 3'd4,
        SLOT_AUXA_LEN  = 3'd5,
        SLOT_AUXB_BASE = 3'd6
    } slot_e;

    typedef struct packed {
        addr_t base;
        addr_t len;
    } window_t;

    typedef struct packed {
        addr_t phys;
        logic  hit_reg;
        logic  oor;
    } xlate_t;

    // Half-open window test; the bound is widened by one bit so it never wraps.
    function automatic logic in_window(input addr_t a, input window_t w);
        logic [AW:0] top;
        top = {1'b0, w.base} + {1'b0, w.len};
        return ({1'b0, a} >= {1'b0, w.base}) && ({1'b0, a} < top);
    endfunction

endpackage

// File: rtl/apw_cfg_regs.sv
module apw_cfg_regs
    import apw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  addr_t            wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output addr_t            rd_data,
    output window_t          mem_win,
    output window_t          reg_win
);

    addr_t slot_q [NUM_CFG];

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (we && (idx == IDX_W'(g))) begin
                slot_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = slot_q[i];
            end
        end
    end

    assign mem_win.base = slot_q[SLOT_MEM_BASE];
    assign mem_win.len  = slot_q[SLOT_MEM_LEN];
    assign reg_win.base = slot_q[SLOT_REG_BASE];
    assign reg_win.len  = slot_q[SLOT_REG_LEN];

endmodule

// File: rtl/apw_range_map.sv
module apw_range_map
    import apw_pkg::*;
(
    input  addr_t   vaddr,
    input  window_t mem_win,
    input  window_t reg_win,
    output xlate_t  result
);

    logic reg_hit;
    logic mem_hit;

    always_comb begin
        reg_hit = in_window(vaddr, reg_win);
        mem_hit = in_window(vaddr, mem_win);
        result.hit_reg = reg_hit;
        result.oor     = !reg_hit && !mem_hit;
        if (reg_hit) begin
            // Register area lies right after the memory area in physical space.
            result.phys = vaddr - reg_win.base + mem_win.len;
        end else begin
            result.phys = vaddr - mem_win.base;
        end
    end

endmodule

// File: rtl/apw_rsp_stage.sv
module apw_rsp_stage
    import apw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    output logic   in_ready,
    input  xlate_t in_data,
    output logic   out_valid,
    input  logic   out_ready,
    output xlate_t out_data
);

    logic take;

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            if (take) begin
                out_valid <= 1'b1;
                out_data  <= in_data;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
    import apw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [AW-1:0]       cfg_wdata,
    input  logic [IDX_W-1:0]    cfg_rd_idx,
    output logic [AW-1:0]       cfg_rd_data,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [AW-1:0]       req_addr,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic [AW-1:0]       rsp_addr,
    output logic                rsp_hit_reg,
    output logic                rsp_oor
);

    window_t mem_win;
    window_t reg_win;
    xlate_t  comb_res;
    xlate_t  held_res;

    apw_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .idx     (cfg_idx),
        .wdata   (cfg_wdata),
        .rd_idx  (cfg_rd_idx),
        .rd_data (cfg_rd_data),
        .mem_win (mem_win),
        .reg_win (reg_win)
    );

    apw_range_map u_map (
        .vaddr   (req_addr),
        .mem_win (mem_win),
        .reg_win (reg_win),
        .result  (comb_res)
    );

    apw_rsp_stage u_rsp (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_data   (comb_res),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .out_data  (held_res)
    );

    assign rsp_addr    = held_res.phys;
    assign rsp_hit_reg = held_res.hit_reg;
    assign rsp_oor     = held_res.oor;

endmodule

// File: rtl/apw_checker.sv
module apw_checker
    import apw_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [AW-1:0] rsp_addr,
    input logic          rsp_hit_reg,
    input logic          rsp_oor
);

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !rsp_valid); // R1

    AST_HIT_EXCLUDES_OOR: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_hit_reg && rsp_oor)); // R6

    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid); // R8

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr)
            && $stable(rsp_hit_reg) && $stable(rsp_oor))); // R9

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |-> !req_ready); // R9

    AST_FLOW_OPEN: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |-> req_ready); // R11

endmodule

bind addr_window_xlate apw_checker u_apw_checker (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_addr    (rsp_addr),
    .rsp_hit_reg (rsp_hit_reg),
    .rsp_oor     (rsp_oor)
);

// File: tb/tb_addr_window_xlate.sv
module tb_addr_window_xlate;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [31:0] cfg_wdata;
    logic [2:0]  cfg_rd_idx;
    logic [31:0] cfg_rd_data;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic        rsp_valid;
    logic        rsp_ready;
    logic [31:0] rsp_addr;
    logic        rsp_hit_reg;
    logic        rsp_oor;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    addr_window_xlate dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
        .rsp_hit_reg(rsp_hit_reg), .rsp_oor(rsp_oor)
    );

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] pa;
        logic        hit;
        logic        oor;
    } vec_t;

    // Config: mem base 0x40000 len 0x14FC4, reg base 0x300000 len 0x8800
    localparam vec_t VECS [9] = '{
        '{32'h0004_0000, 32'h0000_0000, 1'b0, 1'b0},
        '{32'h0005_4FC3, 32'h0001_4FC3, 1'b0, 1'b0},
        '{32'h0005_4FC4, 32'h0001_4FC4, 1'b0, 1'b1},
        '{32'h0003_FFFC, 32'hFFFF_FFFC, 1'b0, 1'b1},
        '{32'h0030_0000, 32'h0001_4FC4, 1'b1, 1'b0},
        '{32'h0030_87FF, 32'h0001_D7C3, 1'b1, 1'b0},
        '{32'h0030_8800, 32'h002C_8800, 1'b0, 1'b1},
        '{32'h002F_FFFC, 32'h002B_FFFC, 1'b0, 1'b1},
        '{32'h0004_1234, 32'h0000_1234, 1'b0, 1'b0}
    };

    logic [31:0] m_mb, m_ml, m_rb, m_rl;

    function automatic vec_t model(input logic [31:0] a);
        vec_t r;
        logic [32:0] rtop, mtop;
        rtop = {1'b0, m_rb} + {1'b0, m_rl};
        mtop = {1'b0, m_mb} + {1'b0, m_ml};
        r.va  = a;
        r.hit = (a >= m_rb) && ({1'b0, a} < rtop);
        if (r.hit) r.pa = a - m_rb + m_ml;
        else       r.pa = a - m_mb;
        r.oor = !r.hit && ((a < m_mb) || ({1'b0, a} >= mtop));
        return r;
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_rsp(input string req, input vec_t e);
        check(rsp_valid == 1'b1, req, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
        check(rsp_addr == e.pa, req, "rsp_addr", rsp_addr, e.pa);
        check(rsp_hit_reg == e.hit, req, "rsp_hit_reg", {31'd0, rsp_hit_reg}, {31'd0, e.hit});
        check(rsp_oor == e.oor, req, "rsp_oor", {31'd0, rsp_oor}, {31'd0, e.oor});
    endtask

    task automatic cfg_write(input logic [2:0] i, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = i; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic xlate(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        vec_t e;
        rst = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0; cfg_rd_idx = '0;
        req_valid = 1'b0; req_addr = '0; rsp_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check(rsp_valid == 1'b0, "R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        for (int i = 0; i < 8; i++) begin
            cfg_rd_idx = 3'(i); #1;
            check(cfg_rd_data == 32'd0, "R1", "slot", cfg_rd_data, 32'd0);
        end

        // R2: slot writes and readback
        m_mb = 32'h0004_0000; m_ml = 32'h0001_4FC4;
        m_rb = 32'h0030_0000; m_rl = 32'h0000_8800;
        cfg_write(3'd0, m_mb); cfg_write(3'd1, m_ml);
        cfg_write(3'd2, m_rb); cfg_write(3'd3, m_rl);
        cfg_write(3'd4, 32'hA0A0_0001); cfg_write(3'd5, 32'hA0A0_0002);
        cfg_write(3'd6, 32'hA0A0_0003);
        cfg_write(3'd7, 32'hDEAD_BEEF);
        begin
            logic [31:0] expv [8];
            expv = '{m_mb, m_ml, m_rb, m_rl, 32'hA0A0_0001, 32'hA0A0_0002,
                     32'hA0A0_0003, 32'h0};
            for (int i = 0; i < 8; i++) begin
                cfg_rd_idx = 3'(i); #1;
                check(cfg_rd_data == expv[i], "R2", "readback", cfg_rd_data, expv[i]);
            end
        end

        // R3 R4 R5 R6: vector walk
        for (int i = 0; i < 9; i++) begin
            xlate(VECS[i].va);
            check_rsp(VECS[i].hit ? "R4" : (VECS[i].oor ? "R6" : "R5"), VECS[i]);
        end
        // R3: window edges are vectors 4..7
        check(VECS[6].hit == 1'b0 && VECS[5].hit == 1'b1, "R3", "vector table", 32'd0, 32'd0);

        // R7: aux slots do not alter translation
        cfg_write(3'd4, 32'h0030_0000); cfg_write(3'd5, 32'hFFFF_FFFF);
        cfg_write(3'd6, 32'h0005_4FC4);
        xlate(VECS[2].va); check_rsp("R7", VECS[2]);
        xlate(VECS[4].va); check_rsp("R7", VECS[4]);

        // R8: consumed after one edge with rsp_ready high
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8", "rsp_valid after consume", {31'd0, rsp_valid}, 32'd0);

        // R9: stall holds, then R11 accept on release
        rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h0030_0010;
        @(negedge clk);
        e = model(32'h0030_0010);
        check_rsp("R8", e);
        req_addr = 32'h0004_0020;
        for (int k = 0; k < 3; k++) begin
            #1;
            check(req_ready == 1'b0, "R9", "req_ready", {31'd0, req_ready}, 32'd0);
            check_rsp("R9", e);
            @(negedge clk);
        end
        rsp_ready = 1'b1; #1;
        check(req_ready == 1'b1, "R11", "req_ready", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        check_rsp("R11", model(32'h0004_0020));
        // R11: back-to-back stream
        for (int k = 0; k < 4; k++) begin
            req_addr = 32'h0030_0100 + 32'(k * 4);
            @(negedge clk);
            check_rsp("R11", model(32'h0030_0100 + 32'(k * 4)));
        end
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8", "rsp_valid idle", {31'd0, rsp_valid}, 32'd0);

        // R10: config change while response parked
        rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h0004_1000;
        @(negedge clk);
        e = model(32'h0004_1000);
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_idx = 3'd0; cfg_wdata = 32'h0004_0800;
        @(negedge clk);
        cfg_we = 1'b0;
        check_rsp("R10", e);
        m_mb = 32'h0004_0800;
        rsp_ready = 1'b1;
        @(negedge clk);
        // R10: write on the same edge as the accept
        req_valid = 1'b1; req_addr = 32'h0004_2000;
        cfg_we = 1'b1; cfg_idx = 3'd0; cfg_wdata = 32'h0004_1000;
        @(negedge clk);
        cfg_we = 1'b0;
        check_rsp("R10", model(32'h0004_2000));
        m_mb = 32'h0004_1000;
        req_addr = 32'h0004_2000;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R10", model(32'h0004_2000));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule